// File: doc/BRIEF.md
# Fault-to-Break Routing Register

This block is one control and status word that decides which internal fault signals may trip a timer's emergency-stop (break) output. Five fault sources are handled: a core lockup indication, a parity error from each of two on-chip SRAMs, a flash double-bit ECC error and a supply-voltage detector interrupt. Each source has its own enable bit, and that bit is also a lock. Software can set it by writing 1. Only a system reset clears it. Once a source is enabled it cannot be disconnected from the break path.

The voltage-detector enable also drives a freeze output. The power-control register uses this output to make its detector-enable bit and its 3-bit threshold field read-only. Two sticky flags record SRAM parity errors. Hardware sets them, and software clears them by writing 1. The break output is the OR of all enabled faults, registered once. The register sits behind a plain single-cycle read/write port at one parameterised address.

Top module: `fbr_route_top`

## Requirements
- R1: A lock bit (bit 0 core lockup, bit 1 SRAM1 parity, bit 2 voltage detector, bit 3 ECC, bit 4 SRAM2 parity) is set by a write of 1 to its position. A write of 0 leaves it unchanged. Only reset clears it.
- R2: After reset, the register reads 0, `brk_out` is 0 and `pwr_cfg_freeze` is 0.
- R3: The SRAM1 parity error reaches `brk_out` only while lock bit 1 is set.
- R4: The SRAM2 parity error reaches `brk_out` only while lock bit 4 is set.
- R5: The flash double-bit ECC error reaches `brk_out` only while lock bit 3 is set.
- R6: The voltage-detector interrupt reaches `brk_out` only while lock bit 2 is set. `pwr_cfg_freeze` is high exactly while lock bit 2 is set.
- R7: The core lockup signal reaches `brk_out` only while lock bit 0 is set.
- R8: A high SRAM1 parity error input sets flag bit 8 at the next clock edge. A high SRAM2 parity error input sets flag bit 9. The lock bits do not affect the flags.
- R9: Writing 1 to bit 8 or bit 9 clears that flag. Writing 0 leaves it unchanged.
- R10: If an error and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R11: `brk_out` is the OR of all enabled faults and appears one clock edge after the faults are sampled.
- R12: Bits 5 to 7 and 10 to 31 always read 0. A read or write at any other address returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe, one cycle |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, combinational from `addr` |
| sram1_par_err | input | 1 | SRAM1 parity error |
| sram2_par_err | input | 1 | SRAM2 parity error |
| ecc_dbl_err | input | 1 | Flash double-bit ECC error |
| vdet_irq | input | 1 | Voltage detector interrupt |
| core_lockup | input | 1 | Core lockup indication |
| brk_out | output | 1 | Registered break request |
| pwr_cfg_freeze | output | 1 | Write-protect for the power-control detector fields |

## Verification
A write or a hardware error changes the register state at the next rising edge. The read value and `pwr_cfg_freeze` follow that state combinationally, so they are due in the same cycle as the edge. `brk_out` adds one register, so it is due one edge after the faults are sampled. The bench drives every input on the falling edge and checks shortly after a falling edge. For each break vector it checks once before the sampling edge, where `brk_out` must still be low, and once after it, where the routed value is due.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  localparam int N_SRC    = 5;
  localparam int N_FLAG   = 2;
  localparam int LK_CORE  = 0;
  localparam int LK_SRAM1 = 1;
  localparam int LK_VDET  = 2;
  localparam int LK_ECC   = 3;
  localparam int LK_SRAM2 = 4;
  localparam int FL_BASE  = 8;

  // set-only update: a write can raise bits, never lower them
  function automatic logic lock_next(input logic cur, input logic we, input logic wbit);
    return cur | (we & wbit);
  endfunction

  // hardware set has priority over write-1 clear
  function automatic logic flag_next(input logic cur, input logic hit, input logic clr);
    return hit | (cur & ~clr);
  endfunction

  function automatic logic any_routed(input logic [N_SRC-1:0] locks,
                                      input logic [N_SRC-1:0] faults);
    return |(locks & faults);
  endfunction
endpackage

// File: rtl/fbr_lock_bank.sv
module fbr_lock_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic [N-1:0] set_mask,
  output logic [N-1:0] locks
);
  import fbr_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_lock
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) locks[i] <= 1'b0;
      else        locks[i] <= lock_next(locks[i], set_stb, set_mask[i]);
    end

    assert_lock_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
      locks[i] |=> locks[i]);
    assert_lock_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (set_stb && set_mask[i]) |=> locks[i]);
  end
endmodule

// File: rtl/fbr_flag_pair.sv
module fbr_flag_pair #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  import fbr_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= flag_next(flags[i], hit[i], clr[i]);
    end

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> flags[i]);
    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[i]) |-> $past(clr[i] && !hit[i]));
  end
endmodule

// File: rtl/fbr_break_path.sv
module fbr_break_path #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] locks,
  input  logic [N-1:0] faults,
  output logic         brk
);
  import fbr_pkg::*;

  logic routed;
  assign routed = any_routed(locks, faults);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk <= 1'b0;
    else        brk <= routed;
  end

  assert_brk_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    routed |=> brk);
  assert_brk_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> $past(|(locks & faults)));
endmodule

// File: rtl/fbr_route_top.sv
module fbr_route_top #(
  parameter int              ADDR_W   = 4,
  parameter int              DATA_W   = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sram1_par_err,
  input  logic              sram2_par_err,
  input  logic              ecc_dbl_err,
  input  logic              vdet_irq,
  input  logic              core_lockup,
  output logic              brk_out,
  output logic              pwr_cfg_freeze
);
  import fbr_pkg::*;

  localparam int FL_TOP = FL_BASE + N_FLAG - 1;

  logic              sel;
  logic              wr_hit;
  logic [N_SRC-1:0]  locks;
  logic [N_SRC-1:0]  faults;
  logic [N_FLAG-1:0] flags;
  logic [N_FLAG-1:0] par_hit;
  logic [N_FLAG-1:0] flag_clr;
  logic [DATA_W-1:0] image;

  assign sel    = (addr == REG_ADDR);
  assign wr_hit = sel & wr_en;

  always_comb begin
    faults           = '0;
    faults[LK_CORE]  = core_lockup;
    faults[LK_SRAM1] = sram1_par_err;
    faults[LK_VDET]  = vdet_irq;
    faults[LK_ECC]   = ecc_dbl_err;
    faults[LK_SRAM2] = sram2_par_err;
  end

  assign par_hit  = {sram2_par_err, sram1_par_err};
  assign flag_clr = wr_hit ? wr_data[FL_TOP:FL_BASE] : '0;

  fbr_lock_bank #(.N(N_SRC)) u_locks (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_stb  (wr_hit),
    .set_mask (wr_data[N_SRC-1:0]),
    .locks    (locks)
  );

  fbr_flag_pair #(.N(N_FLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (par_hit),
    .clr   (flag_clr),
    .flags (flags)
  );

  fbr_break_path #(.N(N_SRC)) u_brk (
    .clk    (clk),
    .rst_n  (rst_n),
    .locks  (locks),
    .faults (faults),
    .brk    (brk_out)
  );

  always_comb begin
    image                     = '0;
    image[N_SRC-1:0]          = locks;
    image[FL_TOP:FL_BASE]     = flags;
  end

  assign rd_data        = sel ? image : '0;
  assign pwr_cfg_freeze = locks[LK_VDET];

  assert_freeze_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_cfg_freeze) |-> $past(wr_hit && wr_data[LK_VDET]));
  assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cfg_freeze |=> pwr_cfg_freeze);
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_data[FL_BASE] && sram1_par_err) |=> rd_data[FL_BASE] || !sel);
  assert_other_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (rd_data == '0));
endmodule

// File: tb/tb_fbr_route_top.sv
module tb_fbr_route_top;
  localparam int          ADDR_W = 4;
  localparam int          DATA_W = 32;
  localparam logic [3:0]  RADDR  = 4'h6;
  localparam logic [3:0]  OADDR  = 4'h2;
  localparam int          NVEC   = 10;

  // {locks[4:0], faults[4:0], expected break}
  // fault order: 4 sram2, 3 ecc, 2 vdet, 1 sram1, 0 core
  localparam logic [10:0] VEC [NVEC] = '{
    {5'b00000, 5'b11111, 1'b0},  // R11 nothing enabled
    {5'b00010, 5'b00010, 1'b1},  // R3
    {5'b00010, 5'b11101, 1'b0},  // R3 others blocked
    {5'b10000, 5'b10000, 1'b1},  // R4
    {5'b01000, 5'b01000, 1'b1},  // R5
    {5'b00100, 5'b00100, 1'b1},  // R6
    {5'b00001, 5'b00001, 1'b1},  // R7
    {5'b11111, 5'b00000, 1'b0},  // R11 no fault
    {5'b01010, 5'b10101, 1'b0},  // R11 disjoint
    {5'b11111, 5'b01000, 1'b1}   // R11 OR
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = RADDR;
  logic wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic sram1_par_err = 1'b0, sram2_par_err = 1'b0, ecc_dbl_err = 1'b0;
  logic vdet_irq = 1'b0, core_lockup = 1'b0;
  logic brk_out, pwr_cfg_freeze;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fbr_route_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(RADDR)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sram1_par_err(sram1_par_err), .sram2_par_err(sram2_par_err),
    .ecc_dbl_err(ecc_dbl_err), .vdet_irq(vdet_irq), .core_lockup(core_lockup),
    .brk_out(brk_out), .pwr_cfg_freeze(pwr_cfg_freeze)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; addr = RADDR;
    #1;
  endtask

  task automatic set_faults(input logic [4:0] f);
    {sram2_par_err, ecc_dbl_err, vdet_irq, sram1_par_err, core_lockup} = f;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    // R2 reset state
    check("R2 read", rd_data, 32'h0);
    check("R2 brk", {31'b0, brk_out}, 32'h0);
    check("R2 freeze", {31'b0, pwr_cfg_freeze}, 32'h0);

    // table walk: R3 R4 R5 R6 R7 R11
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      wr(RADDR, {27'b0, VEC[v][10:6]});
      @(negedge clk);
      set_faults(VEC[v][5:1]);
      #1;
      check("R11 latency (brk before edge)", {31'b0, brk_out}, 32'h0);
      @(negedge clk);
      #1;
      check($sformatf("R11 route vector %0d", v), {31'b0, brk_out}, {31'b0, VEC[v][0]});
      set_faults(5'b0);
      @(negedge clk);
    end

    // R1 set-only locks
    do_reset();
    wr(RADDR, 32'h0000_001F);
    check("R1 set", rd_data, 32'h1F);
    wr(RADDR, 32'h0);
    check("R1 write0 ignored", rd_data, 32'h1F);
    do_reset(); #1;
    check("R1 reset clears", rd_data, 32'h0);

    // R6 freeze
    wr(RADDR, 32'h4);
    check("R6 freeze high", {31'b0, pwr_cfg_freeze}, 32'h1);
    wr(RADDR, 32'h0);
    check("R6 freeze stays", {31'b0, pwr_cfg_freeze}, 32'h1);

    // R8 flags, locks clear so no break involvement
    do_reset();
    sram1_par_err = 1'b1; @(negedge clk); sram1_par_err = 1'b0; #1;
    check("R8 sram1 flag", rd_data, 32'h100);
    sram2_par_err = 1'b1; @(negedge clk); sram2_par_err = 1'b0; #1;
    check("R8 sram2 flag", rd_data, 32'h300);
    check("R8 no brk without lock", {31'b0, brk_out}, 32'h0);

    // R9 write-1 clear
    wr(RADDR, 32'h0);
    check("R9 write0 keeps flags", rd_data, 32'h300);
    wr(RADDR, 32'h100);
    check("R9 clear bit8", rd_data, 32'h200);

    // R10 set wins over clear
    sram2_par_err = 1'b1;
    wr(RADDR, 32'h200);
    sram2_par_err = 1'b0;
    check("R10 set wins bit9", rd_data, 32'h200);
    sram1_par_err = 1'b1;
    wr(RADDR, 32'h100);
    sram1_par_err = 1'b0;
    check("R10 set wins bit8", rd_data, 32'h300);

    // R12 unused bits and other address
    do_reset();
    wr(OADDR, 32'hFFFF_FFFF);
    check("R12 other addr write ignored", rd_data, 32'h0);
    addr = OADDR; #1;
    check("R12 other addr reads 0", rd_data, 32'h0);
    addr = RADDR;
    wr(RADDR, 32'hFFFF_FFFF);
    check("R12 unused bits 0", rd_data, 32'h1F);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule